// File: doc/BRIEF.md
# Sequential Integer Square Root Unit

This unit takes a 32-bit unsigned operand and computes the integer square root and the remainder, one root bit per clock. A test probe is a one-hot power of four. It starts near the top of the operand range and first slides down past every position that lies above the operand. After that, each cycle compares the working value against the partial result plus the probe. When the test succeeds, it subtracts that sum from the working value and folds the probe into the result.

A host waits for `ready_o`, then presents an operand with a one-cycle `start_i`. Every operation takes a fixed number of cycles, whatever the operand is. Each alignment cycle and each compute cycle consumes one probe position. When the probe runs out, the unit raises `done_o` for one cycle. At the same edge it loads the root and remainder into output registers, which keep their value until the next operation completes.

Top module: `isqrt_seq`

## Requirements
- R1: `ready_o` is high exactly while the unit is idle. A `start_i` seen at a clock edge while `ready_o` is high captures `operand_i`, and `ready_o` is low in the following cycle.
- R2: After an operation, `root_o` equals the largest value r with r*r <= operand, for every 32-bit operand, including 0, 1, perfect squares and 0xFFFFFFFF.
- R3: After an operation, `rem_o` equals operand - root*root. This is never more than 2*root, so it fits in 17 bits.
- R4: `done_o` is high for exactly one cycle. It rises at the 16th rising edge after the edge that accepted `start_i`, and `ready_o` returns high in the same cycle.
- R5: A `start_i` pulse while `ready_o` is low is ignored. The result belongs to the operand captured first, and the latency is unchanged.
- R6: `root_o` and `rem_o` change only at the edge that raises `done_o`. They hold their values through idle cycles and through the following busy period.
- R7: An operand of zero gives root 0 and remainder 0 with no compute step. The probe only slides down until it is exhausted.
- R8: While synchronous reset is high, the unit goes idle with `ready_o` = 1, `done_o` = 0, `root_o` = 0 and `rem_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin an operation (accepted only while ready_o is high) |
| operand_i | input | 32 | Unsigned value whose root is taken |
| ready_o | output | 1 | Unit idle and able to accept start_i |
| done_o | output | 1 | One-cycle completion pulse |
| root_o | output | 16 | Integer square root of the captured operand |
| rem_o | output | 17 | Operand minus root squared |

## Verification
The hardest case to reach is a `start_i` that arrives partway through a run while the operand bus already carries a different value. A wrong design would recapture that value or restart its count. The stimulus drives that situation on purpose: in some runs, a few cycles into the busy period, it pulses `start_i` with an unrelated random operand. It then requires both the result and the 16-cycle latency to match the first operand. Extreme operands also need directed values. Zero, 1, 0xFFFFFFFF, (2^16-1)^2 and its neighbours push the probe through alignment only, or through compute only. Random operands and random perfect squares then cover the mixed cases.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ALIGN = 2'd1,
    ST_CALC  = 2'd2
  } isqrt_state_e;
endpackage

// File: rtl/isqrt_step.sv
// One digit-by-digit trial: compare the working value with result + probe.
module isqrt_step #(
  parameter int OP_W = 32
) (
  input  logic [OP_W-1:0] work_i,
  input  logic [OP_W-1:0] res_i,
  input  logic [OP_W-1:0] probe_i,
  output logic [OP_W-1:0] work_o,
  output logic [OP_W-1:0] res_o
);
  logic [OP_W:0] trial;
  logic          take;

  always_comb begin
    trial  = {1'b0, res_i} + {1'b0, probe_i};
    take   = ({1'b0, work_i} >= trial);
    work_o = take ? (work_i - trial[OP_W-1:0]) : work_i;
    res_o  = take ? ((res_i >> 1) + probe_i) : (res_i >> 1);
  end
endmodule

// File: rtl/isqrt_ctrl.sv
module isqrt_ctrl
  import isqrt_pkg::*;
#(
  parameter int ROOT_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic probe_gt_i,
  input  logic probe_last_i,
  output logic ready_o,
  output logic load_o,
  output logic shift_o,
  output logic step_o,
  output logic finish_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(ROOT_W + 1);

  isqrt_state_e state_q, state_d;
  logic [CNT_W-1:0] busy_cnt;

  always_comb begin
    load_o   = 1'b0;
    shift_o  = 1'b0;
    step_o   = 1'b0;
    finish_o = 1'b0;
    state_d  = state_q;
    case (state_q)
      ST_IDLE: begin
        load_o = start_i;
        if (start_i) state_d = ST_ALIGN;
      end
      ST_ALIGN: begin
        shift_o  = probe_gt_i;
        step_o   = !probe_gt_i;
        finish_o = probe_last_i;
        if (probe_last_i)    state_d = ST_IDLE;
        else if (!probe_gt_i) state_d = ST_CALC;
      end
      ST_CALC: begin
        step_o   = 1'b1;
        finish_o = probe_last_i;
        if (probe_last_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      done_o   <= 1'b0;
      busy_cnt <= '0;
    end else begin
      state_q <= state_d;
      done_o  <= finish_o;
      if (load_o)                busy_cnt <= '0;
      else if (state_q != ST_IDLE) busy_cnt <= busy_cnt + 1'b1;
    end
  end

  assign ready_o = (state_q == ST_IDLE);

  // R1
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (ready_o && start_i) |=> !ready_o);

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ready_o && !finish_o) |=> !ready_o);

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    finish_o |-> (busy_cnt == CNT_W'(ROOT_W - 1)));

  // R4
  busy_bound_chk: assert property (@(posedge clk) disable iff (rst)
    !ready_o |-> (busy_cnt < CNT_W'(ROOT_W)));
endmodule

// File: rtl/isqrt_dpath.sv
module isqrt_dpath #(
  parameter int OP_W   = 32,
  parameter int ROOT_W = OP_W / 2,
  parameter int REM_W  = ROOT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              step_i,
  input  logic              finish_i,
  input  logic [OP_W-1:0]   operand_i,
  output logic              probe_gt_o,
  output logic              probe_last_o,
  output logic [ROOT_W-1:0] root_o,
  output logic [REM_W-1:0]  rem_o
);
  localparam logic [OP_W-1:0] PROBE_INIT = {2'b01, {(OP_W-2){1'b0}}};

  logic [OP_W-1:0] work_q, res_q, probe_q;
  logic [OP_W-1:0] work_s, res_s;
  logic [OP_W-1:0] work_nx, res_nx;

  isqrt_step #(.OP_W(OP_W)) step_i0 (
    .work_i  (work_q),
    .res_i   (res_q),
    .probe_i (probe_q),
    .work_o  (work_s),
    .res_o   (res_s)
  );

  assign work_nx      = step_i ? work_s : work_q;
  assign res_nx       = step_i ? res_s  : res_q;
  assign probe_gt_o   = (probe_q > work_q);
  assign probe_last_o = (probe_q[OP_W-1:2] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q  <= '0;
      res_q   <= '0;
      probe_q <= '0;
      root_o  <= '0;
      rem_o   <= '0;
    end else begin
      if (load_i) begin
        work_q  <= operand_i;
        res_q   <= '0;
        probe_q <= PROBE_INIT;
      end else if (shift_i || step_i) begin
        work_q  <= work_nx;
        res_q   <= res_nx;
        probe_q <= probe_q >> 2;
      end
      if (finish_i) begin
        root_o <= res_nx[ROOT_W-1:0];
        rem_o  <= work_nx[REM_W-1:0];
      end
    end
  end

  // R2
  probe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(probe_q));

  // R3
  result_fit_chk: assert property (@(posedge clk) disable iff (rst)
    finish_i |-> ((res_nx[OP_W-1:ROOT_W] == '0) && (work_nx[OP_W-1:REM_W] == '0)));

  // R3
  rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
    finish_i |=> (rem_o <= {root_o, 1'b1}));

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !finish_i |=> ($stable(root_o) && $stable(rem_o)));
endmodule

// File: rtl/isqrt_seq.sv
module isqrt_seq #(
  parameter int OP_W = 32,
  localparam int ROOT_W = OP_W / 2,
  localparam int REM_W  = ROOT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [OP_W-1:0]   operand_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [ROOT_W-1:0] root_o,
  output logic [REM_W-1:0]  rem_o
);
  logic load, shift, step, finish, probe_gt, probe_last;

  isqrt_ctrl #(.ROOT_W(ROOT_W)) ctrl_i (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .probe_gt_i   (probe_gt),
    .probe_last_i (probe_last),
    .ready_o      (ready_o),
    .load_o       (load),
    .shift_o      (shift),
    .step_o       (step),
    .finish_o     (finish),
    .done_o       (done_o)
  );

  isqrt_dpath #(.OP_W(OP_W), .ROOT_W(ROOT_W), .REM_W(REM_W)) dpath_i (
    .clk          (clk),
    .rst          (rst),
    .load_i       (load),
    .shift_i      (shift),
    .step_i       (step),
    .finish_i     (finish),
    .operand_i    (operand_i),
    .probe_gt_o   (probe_gt),
    .probe_last_o (probe_last),
    .root_o       (root_o),
    .rem_o        (rem_o)
  );
endmodule

// File: tb/isqrt_seq_tb_top.sv
module isqrt_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] operand_i = '0;
  logic        ready_o, done_o;
  logic [15:0] root_o;
  logic [16:0] rem_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #10 clk = ~clk;

  isqrt_seq #(.OP_W(32)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .operand_i (operand_i),
    .ready_o   (ready_o),
    .done_o    (done_o),
    .root_o    (root_o),
    .rem_o     (rem_o)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [15:0] ref_root(input logic [31:0] v);
    longint lo = 0;
    longint hi = 65536;
    while (hi - lo > 1) begin
      longint mid = (lo + hi) / 2;
      if (mid * mid <= longint'(v)) lo = mid;
      else hi = mid;
    end
    return 16'(lo);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One operation; if intr is set, pulse start with another operand mid-run.
  task automatic run_op(input logic [31:0] op, input bit intr, input logic [31:0] other);
    logic [15:0] er;
    logic [16:0] em;
    longint      r;
    int          cnt;
    er = ref_root(op);
    em = 17'(longint'(op) - longint'(er) * longint'(er));
    while (!ready_o) @(negedge clk);
    start_i   = 1'b1;
    operand_i = op;
    cnt = 0;
    forever begin
      @(negedge clk);
      start_i = 1'b0;
      if (done_o) break;
      cnt++;
      if (cnt == 2) chk(ready_o == 1'b0, "R1 ready low while busy", ready_o, 0);
      if (intr && cnt == 4) begin
        start_i   = 1'b1;
        operand_i = other;
      end
      if (cnt > 40) break;
    end
    // R4: done seen after the 16th edge following the start edge
    chk(cnt == 16, intr ? "R5 latency unchanged by stray start" : "R4 latency", cnt, 16);
    chk(ready_o == 1'b1, "R4 ready with done", ready_o, 1);
    chk(root_o == er, intr ? "R5 root of first operand" : "R2 root", root_o, er);
    chk(rem_o == em, intr ? "R5 rem of first operand" : "R3 remainder", rem_o, em);
    r = longint'(root_o);
    chk((r * r <= longint'(op)) && (longint'(op) < (r + 1) * (r + 1)),
        "R2 root bracket", r, er);
    chk(rem_o <= {root_o, 1'b1}, "R3 rem bound", rem_o, {root_o, 1'b1});
    @(negedge clk);
    chk(done_o == 1'b0, "R4 done single pulse", done_o, 0);
    chk(root_o == er && rem_o == em, "R6 outputs held", root_o, er);
  endtask

  logic [31:0] directed [14] = '{32'h0, 32'h1, 32'h2, 32'h3, 32'h4, 32'hF, 32'h10,
                                 32'h11, 32'h18, 32'h3FFF_FFFF, 32'h4000_0000,
                                 32'hFFFE_0000, 32'hFFFE_0001, 32'hFFFF_FFFF};

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(ready_o == 1'b1, "R8 ready in reset", ready_o, 1);
    chk(done_o == 1'b0, "R8 done in reset", done_o, 0);
    chk(root_o == 16'd0 && rem_o == 17'd0, "R8 outputs cleared", root_o, 0);
    rst = 1'b0;
    @(negedge clk);

    // R7 zero operand
    run_op(32'h0, 1'b0, 32'h0);
    chk(root_o == 16'd0 && rem_o == 17'd0, "R7 zero operand", rem_o, 0);

    foreach (directed[i]) run_op(directed[i], 1'b0, 32'h0);

    // R5 stray start while busy, followed by idle hold (R6)
    run_op(32'd1000000, 1'b1, 32'hFFFF_FFFF);
    begin
      logic [15:0] hr;
      hr = root_o;
      repeat (5) @(negedge clk);
      chk(root_o == hr, "R6 hold through idle", root_o, hr);
    end
    run_op(32'd5, 1'b1, 32'd0);

    for (int k = 0; k < 150; k++) begin
      logic [31:0] v;
      v = $urandom();
      case (k % 4)
        0: v = v >> ($urandom() % 32);
        1: begin
          logic [15:0] s;
          s = 16'($urandom());
          v = 32'(s) * 32'(s);
        end
        default: ;
      endcase
      run_op(v, (k % 10) == 3, $urandom());
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule